// File: doc/BRIEF.md
# Buck Converter Cycle-Mode Controller

This block chooses between two operating modes of a switching regulator: idle with the power stage off, or an endless run of charging cycles. The choice follows a filtered under-voltage flag. The block talks to two neighbours, and each link is a four-phase request/acknowledge handshake that this block drives as the active side.

The first neighbour filters the raw under-voltage comparator. When the controller asserts `uvCtrl`, that filter waits for the voltage to be low enough and then answers with `uvSan` high. When the controller drops `uvCtrl`, the filter waits for the under-voltage to clear and then drops `uvSan`. The second neighbour is the charge sequencer. A `chrgReq`/`chrgAck` handshake asks it for exactly one charging cycle.

In run mode two events compete. One is the falling flag, which asks to stop. The other is an idle charge handshake, which asks for one more cycle. Each event raises its own claim line, and a two-way mutual-exclusion arbiter grants exactly one of them. A grant is held until its claim is withdrawn. When both claims arrive in the same clock cycle, a fixed priority decides, and by default stopping wins. As a result, a flag that falls during a cycle lets that cycle finish, and at most one further cycle can slip in.

Top module: `buck_cycle_ctrl`

## Requirements
- R1: A synchronous active-high reset drives `uvCtrl` and `chrgReq` low. Once reset is released with `uvSan` low, `uvCtrl` rises within two clock cycles.
- R2: While the controller waits for the flag (`uvCtrl` high, `uvSan` low), `chrgReq` stays low, however long the wait lasts.
- R3: If `uvSan` is high while `uvCtrl` is high, `uvCtrl` falls at the next clock edge. `uvCtrl` never rises while `uvSan` is still high.
- R4: In run mode with the flag high, the controller repeats full charge handshakes. `chrgReq` rises and stays high until `chrgAck` is high, then falls. The next request is issued only after `chrgAck` has returned low. When the acknowledge follows each edge of `chrgReq` after d clock cycles, consecutive rises of `chrgReq` are exactly 5 + 2d cycles apart.
- R5: After `uvSan` falls in run mode, `chrgReq` rises at most once more. After that, `uvCtrl` rises again, and `chrgReq` stays low for as long as the flag stays low.
- R6: Stopping and starting a cycle are mutually exclusive, and a grant is held until its claim is withdrawn. On a same-cycle tie, stopping wins, so a flag that falls during an active charge handshake causes no further `chrgReq` rise.
- R7: `chrgReq` never rises while `chrgAck` is high.
- R8: Once the flag is high again after a stop, charging cycles resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| uvSan | input | 1 | Filtered under-voltage flag (acknowledge of the flag handshake) |
| chrgAck | input | 1 | Acknowledge from the charge sequencer |
| uvCtrl | output | 1 | Request to the flag filter: high means wait for under-voltage, low means wait for it to clear |
| chrgReq | output | 1 | Request for one charging cycle |

## Verification
The charge handshake is run with acknowledge delays from zero to three cycles. The exact spacing between requests separates the phases of the handshake, since a missing or extra state shifts the period by a whole cycle. The flag is dropped at every offset within one charge period, across several delays. This shows that the race between stopping and starting resolves to at most one extra cycle and always ends in the waiting state. A directed case drops the flag while the acknowledge is held high, so both claims arrive in the same cycle. That case separates the stop-first priority from the opposite order. Long waits with the flag low and with a stuck acknowledge show that no request leaks out of the idle state or out of an unfinished handshake.

// File: rtl/cyc_pkg.sv
package cyc_pkg;

  typedef enum logic [1:0] {
    MODE_ARM  = 2'd0,
    MODE_WAIT = 2'd1,
    MODE_RUN  = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_REQ  = 2'd1,
    PH_REL  = 2'd2,
    PH_GAP  = 2'd3
  } phase_e;

  typedef struct packed {
    logic runMode;
    logic cycleGrant;
  } strobes_t;

  localparam int NUM_CLAIMS = 2;

endpackage

// File: rtl/cyc_mutex.sv
module cyc_mutex #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] claims,
  output logic [N-1:0] grants
);

  logic [N-1:0] gntQ;
  logic [N-1:0] gntD;
  logic [N-1:0] lowest;

  // one-hot of the lowest-index claim: fixed priority
  assign lowest = claims & (~claims + N'(1));

  always_comb begin
    if (|gntQ) begin
      gntD = gntQ & claims;   // hold while claimed, release one cycle
    end else begin
      gntD = lowest;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gntQ <= '0;
    end else begin
      gntQ <= gntD;
    end
  end

  assign grants = gntQ;

endmodule

// File: rtl/cyc_control.sv
module cyc_control
  import cyc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     uvSan,
  input  logic     stopGrant,
  input  logic     cycleGrant,
  output logic     uvCtrl,
  output logic     stopClaim,
  output strobes_t strobes
);

  mode_e modeQ;
  mode_e modeD;

  always_comb begin
    modeD = modeQ;
    unique case (modeQ)
      MODE_ARM:  if (!uvSan)    modeD = MODE_WAIT;
      MODE_WAIT: if (uvSan)     modeD = MODE_RUN;
      MODE_RUN:  if (stopGrant) modeD = MODE_ARM;
      default:                  modeD = MODE_ARM;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ <= MODE_ARM;
    end else begin
      modeQ <= modeD;
    end
  end

  assign uvCtrl             = (modeQ == MODE_WAIT);
  assign stopClaim          = (modeQ == MODE_RUN) && !uvSan;
  assign strobes.runMode    = (modeQ == MODE_RUN);
  assign strobes.cycleGrant = cycleGrant;

endmodule

// File: rtl/cyc_datapath.sv
module cyc_datapath
  import cyc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  strobes_t strobes,
  input  logic     chrgAck,
  output logic     chrgReq,
  output logic     cycleClaim
);

  phase_e phaseQ;
  phase_e phaseD;

  always_comb begin
    phaseD = phaseQ;
    unique case (phaseQ)
      PH_IDLE: if (strobes.runMode && strobes.cycleGrant) phaseD = PH_REQ;
      PH_REQ:  if (chrgAck)  phaseD = PH_REL;
      PH_REL:  if (!chrgAck) phaseD = PH_GAP;
      PH_GAP:                phaseD = PH_IDLE;
      default:               phaseD = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseQ <= PH_IDLE;
    end else begin
      phaseQ <= phaseD;
    end
  end

  assign chrgReq    = (phaseQ == PH_REQ);
  assign cycleClaim = strobes.runMode && (phaseQ != PH_GAP) &&
                      !((phaseQ == PH_IDLE) && chrgAck);

endmodule

// File: rtl/buck_cycle_ctrl.sv
module buck_cycle_ctrl
  import cyc_pkg::*;
#(
  parameter bit STOP_FIRST = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic uvSan,
  input  logic chrgAck,
  output logic uvCtrl,
  output logic chrgReq
);

  localparam int STOP_IDX  = STOP_FIRST ? 0 : 1;
  localparam int CYCLE_IDX = 1 - STOP_IDX;

  logic [NUM_CLAIMS-1:0] claims;
  logic [NUM_CLAIMS-1:0] grants;
  logic     stopClaim;
  logic     cycleClaim;
  logic     stopGrant;
  logic     cycleGrant;
  strobes_t strobes;

  assign claims[STOP_IDX]  = stopClaim;
  assign claims[CYCLE_IDX] = cycleClaim;
  assign stopGrant         = grants[STOP_IDX];
  assign cycleGrant        = grants[CYCLE_IDX];

  cyc_control u_control (
    .clk        (clk),
    .rst        (rst),
    .uvSan      (uvSan),
    .stopGrant  (stopGrant),
    .cycleGrant (cycleGrant),
    .uvCtrl     (uvCtrl),
    .stopClaim  (stopClaim),
    .strobes    (strobes)
  );

  cyc_mutex #(.N(NUM_CLAIMS)) u_mutex (
    .clk    (clk),
    .rst    (rst),
    .claims (claims),
    .grants (grants)
  );

  cyc_datapath u_datapath (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .chrgAck    (chrgAck),
    .chrgReq    (chrgReq),
    .cycleClaim (cycleClaim)
  );

endmodule

// File: rtl/cyc_checker.sv
module cyc_checker (
  input logic clk,
  input logic rst,
  input logic uvSan,
  input logic chrgAck,
  input logic uvCtrl,
  input logic chrgReq,
  input logic stopClaim,
  input logic cycleClaim,
  input logic stopGrant,
  input logic cycleGrant
);

  p_wait_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    uvCtrl |-> !chrgReq);

  p_uv_four_phase_r3: assert property (@(posedge clk) disable iff (rst)
    (!uvCtrl && uvSan) |=> !uvCtrl);

  p_req_held_r4: assert property (@(posedge clk) disable iff (rst)
    (chrgReq && !chrgAck) |=> chrgReq);

  p_stop_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    stopGrant |=> !chrgReq);

  p_grant_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(stopGrant && cycleGrant));

  p_cycle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (cycleGrant && cycleClaim) |=> cycleGrant);

  p_stop_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (stopGrant && stopClaim) |=> stopGrant);

  p_no_rearm_r7: assert property (@(posedge clk) disable iff (rst)
    (!chrgReq && chrgAck) |=> !chrgReq);

endmodule

bind buck_cycle_ctrl cyc_checker u_cyc_checker (
  .clk        (clk),
  .rst        (rst),
  .uvSan      (uvSan),
  .chrgAck    (chrgAck),
  .uvCtrl     (uvCtrl),
  .chrgReq    (chrgReq),
  .stopClaim  (stopClaim),
  .cycleClaim (cycleClaim),
  .stopGrant  (stopGrant),
  .cycleGrant (cycleGrant)
);

// File: tb/test_buck_cycle_ctrl.sv
module test_buck_cycle_ctrl;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic uvSan = 1'b0;
  logic chrgAck = 1'b0;
  logic uvCtrl;
  logic chrgReq;

  int checks = 0;
  int failures = 0;
  int edgeCnt = 0;
  int riseCnt = 0;
  int lastRise = 0;
  bit riseValid = 1'b0;
  bit periodOn = 1'b0;
  bit prevReq = 1'b0;
  bit prevUv = 1'b0;

  bit uvLevel = 1'b0;
  int ackDelay = 0;
  bit ackHold = 1'b0;
  int ackCnt = 0;

  always #5 clk = ~clk;

  buck_cycle_ctrl i_buck_cycle_ctrl (
    .clk     (clk),
    .rst     (rst),
    .uvSan   (uvSan),
    .chrgAck (chrgAck),
    .uvCtrl  (uvCtrl),
    .chrgReq (chrgReq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    edgeCnt++;
    if (edgeCnt > 100000) begin
      chk(1'b0, "watchdog", edgeCnt, 100000);
      finishRun();
    end
  end

  // monitor first, then environment models, at the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (chrgReq && !prevReq) begin
        riseCnt++;
        chk(!chrgAck, "R7 request rose with ack high", int'(chrgAck), 0);
        if (periodOn && riseValid)
          chk(edgeCnt - lastRise == 5 + 2 * ackDelay, "R4 request period",
              edgeCnt - lastRise, 5 + 2 * ackDelay);
        lastRise = edgeCnt;
        riseValid = 1'b1;
      end
      if (uvCtrl && !prevUv)
        chk(!uvSan, "R3 uvCtrl rose with uvSan high", int'(uvSan), 0);
      prevReq = chrgReq;
      prevUv = uvCtrl;
      // flag filter model
      if (uvCtrl && uvLevel) uvSan <= 1'b1;
      else if (!uvCtrl && !uvLevel) uvSan <= 1'b0;
      // charge sequencer model
      if (chrgReq != chrgAck) begin
        if (ackCnt >= ackDelay && !(chrgAck && ackHold)) begin
          chrgAck <= chrgReq;
          ackCnt = 0;
        end else begin
          ackCnt++;
        end
      end else begin
        ackCnt = 0;
      end
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  task automatic waitRises(input int n, input string tag);
    int base;
    int t;
    base = riseCnt;
    t = 0;
    while (riseCnt < base + n && t < 200) begin
      cyc(1);
      t++;
    end
    chk(riseCnt >= base + n, tag, riseCnt - base, n);
  endtask

  task automatic waitUvCtrl(input string tag);
    int t;
    t = 0;
    while (!uvCtrl && t < 80) begin
      cyc(1);
      t++;
    end
    chk(uvCtrl, tag, int'(uvCtrl), 1);
  endtask

  initial begin
    int base;
    cyc(3);
    chk(!uvCtrl && !chrgReq, "R1 reset outputs low", int'({uvCtrl, chrgReq}), 0);
    rst = 1'b0;
    cyc(2);
    chk(uvCtrl, "R1 uvCtrl raised after reset", int'(uvCtrl), 1);

    base = riseCnt;
    cyc(30);
    chk(riseCnt == base, "R2 no request while waiting", riseCnt - base, 0);
    chk(uvCtrl, "R2 still waiting on flag", int'(uvCtrl), 1);

    uvLevel = 1'b1;
    while (!uvSan) cyc(1);
    cyc(1);
    chk(!uvCtrl, "R3 uvCtrl dropped after uvSan", int'(uvCtrl), 0);

    for (int d = 0; d <= 3; d++) begin
      periodOn = 1'b0;
      ackDelay = d;
      waitRises(2, "R4 cycles running");
      riseValid = 1'b0;
      periodOn = 1'b1;
      waitRises(4, "R4 cycles repeated");
    end
    periodOn = 1'b0;

    // tie: flag falls during an active handshake with ack held high
    ackDelay = 0;
    ackHold = 1'b1;
    while (!(chrgAck && !chrgReq)) cyc(1);
    uvLevel = 1'b0;
    cyc(5);
    base = riseCnt;
    ackHold = 1'b0;
    waitUvCtrl("R6 stop after tie");
    cyc(20);
    chk(riseCnt == base, "R6 no extra cycle on tie", riseCnt - base, 0);

    uvLevel = 1'b1;
    waitRises(2, "R8 cycles resume");

    for (int d = 0; d <= 2; d++) begin
      ackDelay = d;
      for (int off = 0; off < 5 + 2 * d; off++) begin
        uvLevel = 1'b1;
        waitRises(1, "R8 resume in sweep");
        cyc(off);
        base = riseCnt;
        uvLevel = 1'b0;
        waitUvCtrl("R5 returns to waiting");
        chk(riseCnt - base <= 1, "R5 at most one extra cycle", riseCnt - base, 1);
        base = riseCnt;
        cyc(15);
        chk(riseCnt == base, "R5 quiet while flag low", riseCnt - base, 0);
      end
    end

    finishRun();
  end

endmodule